// File: doc/BRIEF.md
# Modulo-3 Running-Sum Accumulator

This block keeps a running total of small operands, reduced modulo three. A two-bit sum register starts at zero. In each clock cycle where the strobe is high and the operand is a legal residue (0, 1 or 2), the register takes the remainder of the old total plus the operand divided by three. The result output is the register itself, so a new total appears one clock after the operand that produced it.

The two-bit code 11 is not a legal residue. An operand of 11 presented with the strobe is refused: the total does not move, and an error flag is raised for exactly one cycle. The state code 11 cannot arise in normal operation. If it ever appears, for example after an upset, the next clock returns the register to 00. The modulus and the implementation of the adder (arithmetic compare-and-subtract, or hand-derived sum-of-products equations) are parameters, and both are checked at elaboration.

Top module: `modacc_top`

## Requirements
- R1: When the synchronous active-high reset is sampled high at a clock edge, the result becomes 00 and the error flag becomes 0 after that edge.
- R2: With the strobe high and a legal operand (00, 01 or 10), the result after the edge equals (previous result + operand) mod 3. For example, 10 plus 10 gives 01.
- R3: With the strobe low, the result does not change at the edge, whatever value the operand carries.
- R4: With the strobe high and operand 11, the result does not change, and the error flag reads 1 for the single cycle after that edge.
- R5: The error flag reads 0 after any edge where the strobe was low or the operand was legal.
- R6: The result only ever shows the codes 00, 01 and 10. If the stored code is ever 11, the next clock edge clears it to 00.
- R7: Reset takes priority over a strobed operand presented at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| operand | input | 2 | Operand residue; 11 is illegal |
| sum_out | output | 2 | Stored running sum (00, 01, 10) |
| bad_operand | output | 1 | One-cycle flag for a strobed illegal operand |

## Verification
The assertions assume that reset is held high at the first clock edge and that the strobe and operand carry clean 0/1 values at every edge after that. The bench meets this by holding reset from time zero and by changing inputs only on the falling edge. Since the stored code 11 cannot be reached from the ports, the recovery rule is only watched by an assertion, and the bench checks at every cycle that 11 never appears on the result.

// File: rtl/modacc_pkg.sv
package modacc_pkg;

   // Selects the implementation of the modular adder
   typedef enum logic [0:0] {
      IMPL_ARITH = 1'b0,   // compare-and-subtract on a widened sum
      IMPL_GATES = 1'b1    // fixed sum-of-products equations, modulus 3 only
   } impl_e;

   localparam int unsigned MOD_MIN = 2;
   localparam int unsigned MOD_MAX = 16;

   function automatic int unsigned mod_add(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned m);
      return (a + b) % m;
   endfunction

endpackage

// File: rtl/modacc_operand_gate.sv
module modacc_operand_gate #(
   parameter int unsigned MOD = 3,
   parameter int unsigned W   = 2
) (
   input  logic         strobe_i,
   input  logic [W-1:0] operand_i,
   output logic         take_o,
   output logic         refuse_o
);
   localparam logic [W:0] MODV = (W+1)'(MOD);

   logic legal;

   always_comb begin
      legal    = ({1'b0, operand_i} < MODV);
      take_o   = strobe_i & legal;
      refuse_o = strobe_i & ~legal;
   end

endmodule

// File: rtl/modacc_modadd.sv
module modacc_modadd #(
   parameter int unsigned      MOD  = 3,
   parameter int unsigned      W    = 2,
   parameter modacc_pkg::impl_e IMPL = modacc_pkg::IMPL_GATES
) (
   input  logic [W-1:0] acc_i,
   input  logic [W-1:0] add_i,
   output logic [W-1:0] sum_o
);
   localparam logic [W:0] MODV = (W+1)'(MOD);

   generate
      if (IMPL == modacc_pkg::IMPL_GATES) begin : g_gates
         if (MOD != 3 || W != 2) begin : g_bad
            $error("IMPL_GATES needs MOD = 3");
         end
         logic y1, y0, x1, x0;
         always_comb begin
            {y1, y0} = acc_i[1:0];
            {x1, x0} = add_i[1:0];
            // result bit 1 set for 0+2, 1+1, 2+0
            sum_o[1] = (~y1 & ~y0 &  x1 & ~x0) |
                       (~y1 &  y0 & ~x1 &  x0) |
                       ( y1 & ~y0 & ~x1 & ~x0);
            // result bit 0 set for 0+1, 1+0, 2+2
            sum_o[0] = (~y1 & ~y0 & ~x1 &  x0) |
                       (~y1 &  y0 & ~x1 & ~x0) |
                       ( y1 & ~y0 &  x1 & ~x0);
         end
      end else begin : g_arith
         logic [W:0] raw;
         always_comb begin
            raw   = {1'b0, acc_i} + {1'b0, add_i};
            sum_o = (raw >= MODV) ? W'(raw - MODV) : W'(raw);
         end
      end
   endgenerate

   // R2: legal inputs always give a legal residue
   always_comb begin
      if (({1'b0, acc_i} < MODV) && ({1'b0, add_i} < MODV)) begin
         a_r2_in_range: assert ({1'b0, sum_o} < MODV)
            else $error("modular sum out of range");
      end
   end

endmodule

// File: rtl/modacc_sum_reg.sv
module modacc_sum_reg #(
   parameter int unsigned MOD = 3,
   parameter int unsigned W   = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         take_i,
   input  logic         refuse_i,
   input  logic [W-1:0] next_i,
   output logic [W-1:0] sum_o,
   output logic         flag_o
);
   localparam logic [W:0] MODV = (W+1)'(MOD);

   logic state_bad;

   always_comb state_bad = ({1'b0, sum_o} >= MODV);

   always_ff @(posedge clk) begin
      if (rst) begin
         sum_o  <= '0;
         flag_o <= 1'b0;
      end else begin
         flag_o <= refuse_i;
         if (state_bad)
            sum_o <= '0;
         else if (take_i)
            sum_o <= next_i;
      end
   end

   // R1 / R7: reset clears both registers whatever else is presented
   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (sum_o == '0) && !flag_o);

   // R3: no strobe, no movement (legal state)
   a_r3_hold: assert property (@(posedge clk) disable iff (rst)
      (!take_i && !refuse_i && !state_bad) |=> $stable(sum_o));

   // R4: refused operand keeps the sum and raises the flag once
   a_r4_refuse: assert property (@(posedge clk) disable iff (rst)
      (refuse_i && !state_bad) |=> (flag_o && $stable(sum_o)));

   // R5: the flag is low unless an operand was refused
   a_r5_flag_quiet: assert property (@(posedge clk) disable iff (rst)
      !refuse_i |=> !flag_o);

   // R6: a bad state code is cleared at the next edge
   a_r6_recover: assert property (@(posedge clk) disable iff (rst)
      state_bad |=> (sum_o == '0));

   // R6: the bad code is never seen
   a_r6_legal_code: assert property (@(posedge clk) disable iff (rst)
      !state_bad);

endmodule

// File: rtl/modacc_top.sv
module modacc_top #(
   parameter int unsigned       MOD  = 3,
   parameter modacc_pkg::impl_e IMPL = modacc_pkg::IMPL_GATES,
   localparam int unsigned      W    = (MOD < 2) ? 1 : $clog2(MOD)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [W-1:0] operand,
   output logic [W-1:0] sum_out,
   output logic         bad_operand
);
   localparam logic [W:0] MODV = (W+1)'(MOD);

   generate
      if (MOD < modacc_pkg::MOD_MIN || MOD > modacc_pkg::MOD_MAX) begin : g_mod_check
         $error("MOD outside supported range");
      end
   endgenerate

   logic         take;
   logic         refuse;
   logic [W-1:0] next_sum;

   modacc_operand_gate #(.MOD(MOD), .W(W)) u_gate (
      .strobe_i  (in_valid),
      .operand_i (operand),
      .take_o    (take),
      .refuse_o  (refuse)
   );

   modacc_modadd #(.MOD(MOD), .W(W), .IMPL(IMPL)) u_add (
      .acc_i (sum_out),
      .add_i (operand),
      .sum_o (next_sum)
   );

   modacc_sum_reg #(.MOD(MOD), .W(W)) u_reg (
      .clk      (clk),
      .rst      (rst),
      .take_i   (take),
      .refuse_i (refuse),
      .next_i   (next_sum),
      .sum_o    (sum_out),
      .flag_o   (bad_operand)
   );

   // R2: a strobed legal operand gives the modular sum one cycle later
   a_r2_add: assert property (@(posedge clk) disable iff (rst)
      (in_valid && ({1'b0, operand} < MODV) && ({1'b0, sum_out} < MODV))
      |=> (int'(sum_out) ==
           modacc_pkg::mod_add(int'($past(sum_out)), int'($past(operand)), MOD)));

endmodule

// File: tb/tb_modacc_top.sv
module tb_modacc_top;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [1:0] sum;
      logic       flag;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [1:0] operand = 2'b00;
   logic [1:0] sum_out;
   logic       bad_operand;

   int   checks = 0;
   int   failures = 0;
   bit   done = 1'b0;
   exp_t q[$];
   logic [1:0] model_sum = 2'b00;

   modacc_top dut (
      .clk         (clk),
      .rst         (rst),
      .in_valid    (in_valid),
      .operand     (operand),
      .sum_out     (sum_out),
      .bad_operand (bad_operand)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // driver: drive on the falling edge, push the expected result of the next edge
   task automatic drive(input logic r, input logic v, input logic [1:0] op);
      exp_t e;
      @(negedge clk);
      rst = r; in_valid = v; operand = op;
      if (r) begin
         model_sum = 2'b00; e.flag = 1'b0; e.tag = v ? "R7" : "R1";
      end else if (v && op == 2'b11) begin
         e.flag = 1'b1; e.tag = "R4";
      end else if (v) begin
         model_sum = 2'((int'(model_sum) + int'(op)) % 3); e.flag = 1'b0; e.tag = "R2";
      end else begin
         e.flag = 1'b0; e.tag = "R3";
      end
      e.sum = model_sum;
      q.push_back(e);
   endtask

   // monitor: compare a quarter period after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_PERIOD/4);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (sum_out !== e.sum) begin
               failures++;
               $display("FAIL %s sum actual=%b expected=%b", e.tag, sum_out, e.sum);
            end
            checks++;
            if (bad_operand !== e.flag) begin
               failures++;
               $display("FAIL %s flag actual=%b expected=%b",
                        e.flag ? "R4" : "R5", bad_operand, e.flag);
            end
            checks++;
            if (sum_out === 2'b11) begin
               failures++;
               $display("FAIL R6 code actual=%b expected=not 11", sum_out);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      drive(1'b1, 1'b0, 2'b00);          // R1 reset state
      drive(1'b0, 1'b1, 2'b01);          // R2 0+1
      drive(1'b0, 1'b1, 2'b01);          // R2 1+1
      drive(1'b0, 1'b1, 2'b10);          // R2 2+2 -> 1
      drive(1'b0, 1'b0, 2'b10);          // R3 ignored operand
      drive(1'b0, 1'b0, 2'b11);          // R3 ignored illegal code
      drive(1'b0, 1'b1, 2'b11);          // R4 refused
      drive(1'b0, 1'b1, 2'b00);          // R5 flag drops
      drive(1'b0, 1'b1, 2'b11);          // R4 back to back
      drive(1'b0, 1'b1, 2'b11);
      drive(1'b0, 1'b1, 2'b01);
      drive(1'b1, 1'b1, 2'b10);          // R7 reset beats strobe
      drive(1'b0, 1'b1, 2'b10);
      drive(1'b1, 1'b1, 2'b11);          // R7 reset beats refusal
      // R2 every state against every legal operand
      for (int s = 0; s < 3; s++) begin
         for (int o = 0; o < 3; o++) begin
            drive(1'b1, 1'b0, 2'b00);
            if (s != 0) drive(1'b0, 1'b1, 2'(s));
            drive(1'b0, 1'b1, 2'(o));
         end
      end
      // mixed traffic
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         drive(lfsr[7:0] == 8'h00, lfsr[3], lfsr[1:0]);
      end
      wait (q.size() == 0);
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule